// File: doc/BRIEF.md
# Retriggerable programmable delay timer

This block is a digital one-shot. An edge on either of two trigger inputs starts an output pulse. The rising edge counts on `trig_a` and the falling edge counts on `trig_b`. While the pulse is active, a wide binary counter advances on each tick of a local oscillator model. When the count reaches the terminal value picked by a 4-bit select code, every counter stage clears and the pulse ends. The oscillator is a clock divider that produces one tick every `OSC_DIV` clocks. It can run all the time, or it can be held in reset while idle and released only for the length of a pulse.

There are two retrigger policies. In the retrigger policy, a new trigger during a pulse restarts the count, so a steady stream of triggers holds the pulse high indefinitely. In the lock-out policy, the pulse ignores the trigger inputs once it has started. The highest select code does not set a delay. Instead it splits the counter into equal sections that all advance together from the same tick, so that every stage can be exercised in a few ticks.

The controller has two states. `ST_IDLE` means no pulse is active and `ST_RUN` means a pulse is active. It has four named moves:
- START: `ST_IDLE` to `ST_RUN` on a trigger.
- EXTEND: `ST_RUN` to `ST_RUN` on a trigger while retrigger is enabled. The count clears.
- EXPIRE: `ST_RUN` to `ST_IDLE` when the terminal count is reached.
- ABORT: an asynchronous move to `ST_IDLE` from master reset or power-on reset.

Top module: `dly_timer`

## Requirements
- R1: A low-to-high change on `trig_a` makes `q` high at the third rising clock edge after the change. The change passes through two synchronizer flops and one edge register on the way. When `trig_a` and `trig_b` are driven with the same value, both the rising and the falling transition start a pulse.
- R2: A high-to-low change on `trig_b` starts a pulse with the same three-edge latency. A falling `trig_a` and a rising `trig_b` never start a pulse.
- R3: For select codes 0 to 14, the terminal count is 2^min(code+`BASE_EXP`, `CNT_W`) ticks. With the gated oscillator, `q` stays high for exactly terminal count × `OSC_DIV` clocks.
- R4: Select code 15 is the test mode. The counter splits into `SEC_W`-bit sections that all advance on the same tick, and the pulse lasts 2^`SEC_W` ticks.
- R5: With `retrig_en` high, a trigger during a pulse clears the counter without dropping `q`. `q` then falls terminal count × `OSC_DIV` clocks after the edge at which that trigger was detected.
- R6: With `retrig_en` low, trigger edges during a pulse have no effect, and the pulse keeps its normal length.
- R7: Raising `mr` drops `q` and raises `qn` before the next clock edge, and clears the counter. Trigger edges that arrive while `mr` is high start no pulse, either during `mr` or after it is released.
- R8: While `rst_n` is low, `q` is low and `qn` is high, and no pulse follows its release.
- R9: With `osc_free` low, the oscillator is held cleared while idle and restarted by START and EXTEND. With `osc_free` high, the oscillator runs continuously, so a pulse lasts between (terminal count − 1) × `OSC_DIV` + 1 and terminal count × `OSC_DIV` clocks.
- R10: `qn` is always the complement of `q`.
- R11: After EXPIRE the counter is clear, and the next trigger produces a full-length pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| mr | input | 1 | Master reset, active high, asynchronous |
| trig_a | input | 1 | Trigger input, acts on its rising edge |
| trig_b | input | 1 | Trigger input, acts on its falling edge |
| retrig_en | input | 1 | 1 = a trigger during a pulse restarts it, 0 = lock-out |
| osc_free | input | 1 | 1 = oscillator runs always, 0 = oscillator runs only during a pulse |
| sel | input | SEL_W | Delay select code; the all-ones code selects the counter test mode |
| q | output | 1 | Pulse output, active high |
| qn | output | 1 | Complement of `q` |

## Verification
A trigger edge becomes visible to the controller after two synchronizer edges, and `q` changes at the third clock edge. For that reason the bench drives each trigger on a falling clock edge, expects `q` low at the next two falling-edge samples, and starts counting high samples from the third. With the gated oscillator, the pulse then lasts exactly terminal count × `OSC_DIV` samples. After a retrigger at high-sample k, the pulse ends k+2 samples later plus one full pulse length. Master reset is checked one time unit after it rises, before any clock edge, because its effect on `q` does not wait for the clock.

// File: rtl/dt_pkg.sv
package dt_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dt_state_e;

    typedef enum logic [1:0] {
        MV_HOLD   = 2'd0,
        MV_START  = 2'd1,
        MV_EXTEND = 2'd2,
        MV_EXPIRE = 2'd3
    } dt_move_e;

endpackage

// File: rtl/dt_edge_sync.sv
module dt_edge_sync #(
    parameter int   STAGES    = 2,
    parameter bit   RST_VAL   = 1'b0,
    parameter bit   EDGE_RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic hit
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
            prev  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign last = chain[STAGES-1];

    generate
        if (EDGE_RISE) begin : g_rise
            assign hit = last & ~prev;
        end else begin : g_fall
            assign hit = ~last & prev;
        end
    endgenerate

endmodule

// File: rtl/dt_osc_gate.sv
module dt_osc_gate #(
    parameter int OSC_DIV = 1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic free_run,
    input  logic running,
    input  logic restart,
    output logic tick
);
    localparam int DIV_W = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(OSC_DIV - 1);

    logic [DIV_W-1:0] phase;
    logic             hold;

    assign hold = !free_run && (!running || restart);

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            phase <= '0;
        end else if (hold) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = (phase == LAST) && (free_run || running);

endmodule

// File: rtl/dt_counter.sv
module dt_counter #(
    parameter int CNT_W    = 24,
    parameter int SEC_W    = 4,
    parameter int SEL_W    = 4,
    parameter int BASE_EXP = 10
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    localparam int NSEC = CNT_W / SEC_W;

    logic             test;
    logic [NSEC:0]    carry;
    logic [CNT_W-1:0] mask;

    assign test     = &sel;
    assign carry[0] = tick;

    generate
        for (genvar s = 0; s < NSEC; s++) begin : g_sec
            logic [SEC_W-1:0] val;
            logic             cin;

            assign cin = test ? tick : carry[s];

            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    val <= '0;
                end else if (clr) begin
                    val <= '0;
                end else if (cin) begin
                    val <= val + 1'b1;
                end
            end

            assign carry[s+1]             = cin && (&val);
            assign cnt[s*SEC_W +: SEC_W]  = val;
        end
    endgenerate

    always_comb begin
        int e;
        e = int'(sel) + BASE_EXP;
        if (e > CNT_W) e = CNT_W;
        for (int i = 0; i < CNT_W; i++) begin
            mask[i] = (i < e);
        end
    end

    assign done = tick && (test ? (&cnt[SEC_W-1:0]) : ((cnt & mask) == mask));

endmodule

// File: rtl/dt_ctrl.sv
module dt_ctrl
    import dt_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic trig,
    input  logic retrig_en,
    input  logic done,
    output logic q,
    output logic clr,
    output logic restart
);
    dt_state_e state;
    dt_state_e state_nx;
    dt_move_e  move;

    always_comb begin
        move = MV_HOLD;
        unique case (state)
            ST_IDLE: begin
                if (trig) move = MV_START;
            end
            ST_RUN: begin
                if (trig && retrig_en) move = MV_EXTEND;
                else if (done)         move = MV_EXPIRE;
            end
            default: move = MV_HOLD;
        endcase
    end

    always_comb begin
        unique case (move)
            MV_START, MV_EXTEND: state_nx = ST_RUN;
            MV_EXPIRE:           state_nx = ST_IDLE;
            default:             state_nx = state;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= ST_IDLE;
        else         state <= state_nx;
    end

    always_comb begin
        q       = (state == ST_RUN);
        clr     = (state == ST_IDLE) || (move == MV_EXTEND) || (move == MV_EXPIRE);
        restart = (move == MV_EXTEND);
    end

endmodule

// File: rtl/dly_timer.sv
module dly_timer #(
    parameter int CNT_W    = 24,
    parameter int SEC_W    = 4,
    parameter int SEL_W    = 4,
    parameter int BASE_EXP = 10,
    parameter int OSC_DIV  = 1,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mr,
    input  logic             trig_a,
    input  logic             trig_b,
    input  logic             retrig_en,
    input  logic             osc_free,
    input  logic [SEL_W-1:0] sel,
    output logic             q,
    output logic             qn
);
    logic             arst_n;
    logic             a_hit;
    logic             b_hit;
    logic             trig;
    logic             tick;
    logic             done;
    logic             clr;
    logic             restart;
    logic [CNT_W-1:0] cnt;

    assign arst_n = rst_n & ~mr;

    dt_edge_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0), .EDGE_RISE(1'b1)) u_sync_a (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (trig_a),
        .hit   (a_hit)
    );

    dt_edge_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1), .EDGE_RISE(1'b0)) u_sync_b (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (trig_b),
        .hit   (b_hit)
    );

    assign trig = a_hit | b_hit;

    dt_ctrl u_ctrl (
        .clk       (clk),
        .arst_n    (arst_n),
        .trig      (trig),
        .retrig_en (retrig_en),
        .done      (done),
        .q         (q),
        .clr       (clr),
        .restart   (restart)
    );

    dt_osc_gate #(.OSC_DIV(OSC_DIV)) u_osc (
        .clk      (clk),
        .arst_n   (arst_n),
        .free_run (osc_free),
        .running  (q),
        .restart  (restart),
        .tick     (tick)
    );

    dt_counter #(.CNT_W(CNT_W), .SEC_W(SEC_W), .SEL_W(SEL_W), .BASE_EXP(BASE_EXP)) u_cnt (
        .clk    (clk),
        .arst_n (arst_n),
        .clr    (clr),
        .tick   (tick),
        .sel    (sel),
        .cnt    (cnt),
        .done   (done)
    );

    assign qn = ~q;

endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
    parameter int CNT_W = 24,
    parameter int SEC_W = 4,
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mr,
    input logic             q,
    input logic             trig,
    input logic             done,
    input logic             tick,
    input logic             retrig_en,
    input logic             osc_free,
    input logic [SEL_W-1:0] sel,
    input logic [CNT_W-1:0] cnt
);
    logic test;
    assign test = &sel;

    a_r1_start: assert property (@(posedge clk) disable iff (!rst_n || mr)
        (!q && trig) |=> q);

    a_r5_extend_clears: assert property (@(posedge clk) disable iff (!rst_n || mr)
        (q && retrig_en && trig) |=> (q && cnt == '0));

    a_r6_lockout_counts_on: assert property (@(posedge clk) disable iff (!rst_n || mr)
        (q && !retrig_en && !done && tick) |=> (q && cnt != '0));

    a_r11_expire_clears: assert property (@(posedge clk) disable iff (!rst_n || mr)
        (q && done && !(retrig_en && trig)) |=> (!q && cnt == '0));

    a_r9_gated_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n || mr)
        (!osc_free && !q) |-> !tick);

    a_r4_sections_parallel: assert property (@(posedge clk) disable iff (!rst_n || mr)
        (q && test && tick && !done && !(retrig_en && trig)) |=>
        ((cnt[SEC_W-1:0] == SEC_W'($past(cnt[SEC_W-1:0]) + 1'b1)) &&
         (cnt[CNT_W-1 -: SEC_W] == SEC_W'($past(cnt[CNT_W-1 -: SEC_W]) + 1'b1))));

    a_r7_master_reset: assert property (@(posedge clk) disable iff (!rst_n)
        mr |-> (!q && cnt == '0));

endmodule

bind dly_timer dt_checker #(.CNT_W(CNT_W), .SEC_W(SEC_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mr        (mr),
    .q         (q),
    .trig      (trig),
    .done      (done),
    .tick      (tick),
    .retrig_en (retrig_en),
    .osc_free  (osc_free),
    .sel       (sel),
    .cnt       (cnt)
);

// File: tb/tb_dly_timer.sv
module tb_dly_timer;
    localparam int CNT_W = 12;
    localparam int SEC_W = 4;
    localparam int SEL_W = 4;
    localparam int BEXP  = 2;
    localparam int DIV   = 3;
    localparam int CAP   = 14000;

    logic clk = 1'b0;
    logic rst_n, mr, a, b, retrig_en, osc_free;
    logic [SEL_W-1:0] sel;
    logic q, qn;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dly_timer #(.CNT_W(CNT_W), .SEC_W(SEC_W), .SEL_W(SEL_W), .BASE_EXP(BEXP), .OSC_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .mr(mr), .trig_a(a), .trig_b(b),
        .retrig_en(retrig_en), .osc_free(osc_free), .sel(sel), .q(q), .qn(qn)
    );

    function automatic int term_ticks(input int code);
        int e;
        if (code == (1 << SEL_W) - 1) return 1 << SEC_W;
        e = code + BEXP;
        if (e > CNT_W) e = CNT_W;
        return 1 << e;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive triggers, confirm latency, count high samples (optional retrigger events)
    task automatic measure(input logic na, input logic nb, input bit events,
                           input string req, output int len);
        @(negedge clk);
        a = na;
        b = nb;
        repeat (2) @(negedge clk);
        chk(q == 1'b0, {req, " R1 R2 not before third edge"}, int'(q), 0);
        @(negedge clk);
        chk(q == 1'b1, {req, " R1 R2 high at third edge"}, int'(q), 1);
        len = 0;
        while (q && len < CAP) begin
            len++;
            chk(qn == ~q, "R10 qn complement", int'(qn), int'(~q));
            if (events) begin
                case (len)
                    20: b = 1'b0;
                    25: begin a = 1'b0; b = 1'b1; end
                    50: a = 1'b1;
                    55: a = 1'b0;
                    80: b = 1'b0;
                    85: b = 1'b1;
                    default: ;
                endcase
            end
            @(negedge clk);
        end
        chk(qn == 1'b1, "R10 qn high after pulse", int'(qn), 1);
    endtask

    task automatic go_idle();
        @(negedge clk);
        a = 1'b0;
        b = 1'b1;
        repeat (5) @(negedge clk);
        chk(q == 1'b0, "R2 falling A or rising B ignored", int'(q), 0);
    endtask

    initial begin
        int len;
        int exp;
        rst_n = 1'b0; mr = 1'b0; a = 1'b0; b = 1'b1;
        retrig_en = 1'b0; osc_free = 1'b0; sel = '0;
        repeat (3) @(negedge clk);
        chk(q == 1'b0 && qn == 1'b1, "R8 reset state", int'(q), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(q == 1'b0, "R8 no pulse after reset", int'(q), 0);

        // R3 R9: gated sweep over every delay code, A then B
        for (int c = 0; c < 15; c++) begin
            sel = SEL_W'(c);
            exp = term_ticks(c) * DIV;
            if (c % 2 == 0) measure(1'b1, 1'b1, 1'b0, "A", len);
            else            measure(1'b0, 1'b0, 1'b0, "B", len);
            chk(len == exp, $sformatf("R3 R9 gated length code %0d", c), len, exp);
            go_idle();
        end

        // R4: test mode
        sel = '1;
        measure(1'b1, 1'b1, 1'b0, "A", len);
        chk(len == (1 << SEC_W) * DIV, "R4 test mode length", len, (1 << SEC_W) * DIV);
        go_idle();

        // R1: tied inputs, both directions trigger
        sel = SEL_W'(1);
        exp = term_ticks(1) * DIV;
        measure(1'b1, 1'b1, 1'b0, "tied rise", len);
        chk(len == exp, "R1 tied rising", len, exp);
        repeat (4) @(negedge clk);
        measure(1'b0, 1'b0, 1'b0, "tied fall", len);
        chk(len == exp, "R1 tied falling", len, exp);
        go_idle();

        // R5: retrigger extends
        sel = SEL_W'(2);
        retrig_en = 1'b1;
        exp = 82 + term_ticks(2) * DIV;
        measure(1'b1, 1'b1, 1'b1, "retrig", len);
        chk(len == exp, "R5 retrigger extends", len, exp);
        go_idle();

        // R6: lock-out keeps length
        retrig_en = 1'b0;
        exp = term_ticks(2) * DIV;
        measure(1'b1, 1'b1, 1'b1, "lockout", len);
        chk(len == exp, "R6 lock-out length", len, exp);
        go_idle();

        // R9: free-running oscillator bounds
        osc_free = 1'b1;
        for (int c = 0; c < 4; c++) begin
            sel = SEL_W'(c);
            measure(1'b1, 1'b1, 1'b0, "free", len);
            chk(len >= (term_ticks(c) - 1) * DIV + 1 && len <= term_ticks(c) * DIV,
                $sformatf("R9 free length code %0d", c), len, term_ticks(c) * DIV);
            go_idle();
        end
        osc_free = 1'b0;

        // R7: asynchronous master reset
        sel = SEL_W'(5);
        @(negedge clk);
        a = 1'b1;
        repeat (3) @(negedge clk);
        chk(q == 1'b1, "R7 pulse running before mr", int'(q), 1);
        repeat (10) @(negedge clk);
        #1 mr = 1'b1;
        #1 chk(q == 1'b0 && qn == 1'b1, "R7 mr drops q before edge", int'(q), 0);
        @(negedge clk); a = 1'b0;
        @(negedge clk); a = 1'b1;
        @(negedge clk); b = 1'b0;
        repeat (4) @(negedge clk);
        chk(q == 1'b0, "R7 triggers ignored during mr", int'(q), 0);
        mr = 1'b0;
        repeat (6) @(negedge clk);
        chk(q == 1'b0, "R7 no pulse after mr release", int'(q), 0);
        go_idle();

        // R11: fresh full pulse after abort and after expiry
        sel = '0;
        exp = term_ticks(0) * DIV;
        measure(1'b1, 1'b1, 1'b0, "fresh", len);
        chk(len == exp, "R11 full length after mr", len, exp);
        go_idle();
        measure(1'b1, 1'b1, 1'b0, "again", len);
        chk(len == exp, "R11 full length after expiry", len, exp);
        go_idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule